// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address. It walks a four-level radix tree of 8-byte entries held in memory. A client presents a request with the virtual address, the kind of access (read, write or instruction fetch) and the privilege (user or supervisor). The walker first screens the address for canonical form. It then reads one table entry per level through a simple request/response memory port. The first read starts from the root-table base input, and each later read uses the base taken from the entry before it.

Every entry read is checked as soon as it arrives. If the entry is not present, the walk stops. The walker also keeps running permission flags across the levels and stops as soon as the access is no longer allowed. It reports a result on a one-cycle `done_valid` pulse. A successful walk returns the physical address and the combined permission flags. A failed walk returns the virtual address, the level where it stopped and a reason code. Only one walk runs at a time, and `busy` together with `req_ready` holds off new work until the current walk has finished.

Top module: `pt_walker`

## Requirements
- R1: Only bits 47..0 of the virtual address are translated. An address whose bits 63..48 all equal bit 47 is canonical, and that includes the high half where bit 47 is 1. A canonical address is walked normally.
- R2: A non-canonical address produces a fault with reason 5 at level 3 on `done_valid` in the cycle after it is accepted. It issues no memory read.
- R3: Level 3 is the root and level 0 is the leaf. The table index for level L is virtual address bits [12+9L+8 : 12+9L], so level 3 uses bits 47..39 and level 0 uses bits 20..12. Reads go in order from level 3 down to level 0, and the first one uses `root_base` with its low 12 bits taken as zero.
- R4: A walk that succeeds issues exactly four memory reads. A walk that faults issues no more reads after the faulting one.
- R5: Each read address is the table base plus 8 times the index. The next table base is entry bits 51..12 followed by twelve zero bits.
- R6: The physical address of a successful walk is the leaf entry's bits 51..12 followed by virtual address bits 11..0.
- R7: An entry with bit 0 (present) clear ends the walk with reason 1 at that entry's level.
- R8: The access code is 0 for read, 1 for write and 2 for fetch; code 3 is treated as a read. After each present entry the running permissions are checked in this priority order: a user access without the user bit (bit 2) gives reason 3, a write without the writable bit (bit 1) gives reason 2, and a fetch with no-execute (bit 63) gives reason 4. The walk stops at that level.
- R9: On success, `done_writable` and `done_user` are the AND of bits 1 and 2 across all four entries, and `done_nx` is the OR of bit 63 across them. `done_accessed` and `done_dirty` are bits 5 and 6 of the leaf entry.
- R10: A fault reports the request's virtual address on `flt_vaddr`, the stopping level on `flt_level` and the reason on `flt_reason`, with `done_fault` high.
- R11: `busy` is high from the cycle after a request is accepted until the cycle after `done_valid`, and `req_ready` is low whenever `busy` is high.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and its address does not change.
- R13: `done_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 52 | Physical base of the root table (low 12 bits ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Result is a fault |
| done_paddr | output | 52 | Translated physical address |
| done_writable | output | 1 | Writable across all levels |
| done_user | output | 1 | User-accessible across all levels |
| done_nx | output | 1 | No-execute at any level |
| done_accessed | output | 1 | Leaf accessed bit |
| done_dirty | output | 1 | Leaf dirty bit |
| flt_vaddr | output | 64 | Virtual address of the request |
| flt_level | output | 2 | Level at which the walk stopped |
| flt_reason | output | 3 | 1 not present, 2 write protect, 3 privilege, 4 no-execute, 5 non-canonical |

## Verification
The bench builds the walker with its default parameters: a 64-bit virtual address, a 52-bit physical address, 9-bit indices, a 12-bit offset and four levels. These values make the canonical boundary at bit 47 and the 8-byte entry stride show up directly as distinct root slots for every test chain, and they let each of the four levels be made to fault on its own. The memory model runs each scenario twice. The first pass uses zero-wait handshakes. The second pass applies random request back-pressure and response delay, which exercises the hold-stable rule and the serial read ordering under stalls.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // entry flag positions (fixed by the entry format)
  localparam int unsigned PTE_P  = 0;
  localparam int unsigned PTE_RW = 1;
  localparam int unsigned PTE_US = 2;
  localparam int unsigned PTE_A  = 5;
  localparam int unsigned PTE_D  = 6;
  localparam int unsigned PTE_NX = 63;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_NOT_PRESENT = 3'd1,
    FLT_WRITE_PROT  = 3'd2,
    FLT_PRIV        = 3'd3,
    FLT_NO_EXEC     = 3'd4,
    FLT_NONCANON    = 3'd5
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_DONE    = 2'd3
  } walk_st_e;

endpackage

// File: rtl/pt_idx_gen.sv
module pt_idx_gen #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFS_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PA_W-1:0]  tbl_base,
  output logic [PA_W-1:0]  ent_addr,
  output logic             canon
);

  localparam int VA_USED = OFS_W + IDX_W * LEVELS;
  localparam int PTE_LG  = 3;  // 8-byte entries

  function automatic logic is_canon(input logic [VA_W-1:0] a);
    logic [VA_W-VA_USED:0] hi;
    hi = a[VA_W-1:VA_USED-1];
    return (&hi) | ~(|hi);
  endfunction

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    return b + {{(PA_W-IDX_W-PTE_LG){1'b0}}, i, {PTE_LG{1'b0}}};
  endfunction

  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = va[OFS_W + IDX_W*g +: IDX_W];
  end

  assign ent_addr = slot_addr(tbl_base, idx_arr[lvl]);
  assign canon    = is_canon(va);

  logic unused_ofs;
  assign unused_ofs = ^va[OFS_W-1:0];

endmodule

// File: rtl/pt_perm_acc.sv
module pt_perm_acc
  import pt_walk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic pte_p,
  input  logic pte_rw,
  input  logic pte_us,
  input  logic pte_nx,
  input  acc_e acc,
  input  logic usr,
  output flt_e reason,
  output logic eff_w,
  output logic eff_u,
  output logic eff_nx
);

  logic acc_w_q, acc_u_q, acc_nx_q;

  assign eff_w  = acc_w_q & pte_rw;
  assign eff_u  = acc_u_q & pte_us;
  assign eff_nx = acc_nx_q | pte_nx;

  always_comb begin
    if (!pte_p)                            reason = FLT_NOT_PRESENT;
    else if (usr && !eff_u)                reason = FLT_PRIV;
    else if (acc == ACC_WRITE && !eff_w)   reason = FLT_WRITE_PROT;
    else if (acc == ACC_FETCH && eff_nx)   reason = FLT_NO_EXEC;
    else                                   reason = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_w_q  <= 1'b1;
      acc_u_q  <= 1'b1;
      acc_nx_q <= 1'b0;
    end else if (clr) begin
      acc_w_q  <= 1'b1;
      acc_u_q  <= 1'b1;
      acc_nx_q <= 1'b0;
    end else if (upd) begin
      acc_w_q  <= eff_w;
      acc_u_q  <= eff_u;
      acc_nx_q <= eff_nx;
    end
  end

  // R9
  w_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> !$rose(acc_w_q));
  // R9
  u_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> !$rose(acc_u_q));
  // R9
  nx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> !$fell(acc_nx_q));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFS_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] root_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic            req_user,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done_valid,
  output logic            done_fault,
  output logic [PA_W-1:0] done_paddr,
  output logic            done_writable,
  output logic            done_user,
  output logic            done_nx,
  output logic            done_accessed,
  output logic            done_dirty,
  output logic [VA_W-1:0] flt_vaddr,
  output logic [1:0]      flt_level,
  output logic [2:0]      flt_reason
);

  localparam int LVL_W = $clog2(LEVELS);
  localparam int CNT_W = LVL_W + 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  function automatic logic [PA_W-1:0] next_base(input logic [63:0] pte);
    return {pte[PA_W-1:OFS_W], {OFS_W{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] leaf_pa(input logic [63:0] pte,
                                              input logic [VA_W-1:0] a);
    return {pte[PA_W-1:OFS_W], a[OFS_W-1:0]};
  endfunction

  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic             usr_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;

  logic             res_fault;
  flt_e             res_reason;
  logic [LVL_W-1:0] res_level;
  logic [PA_W-1:0]  res_paddr;
  logic             res_w, res_u, res_nx, res_a, res_d;

  // named internal events
  logic req_fire, rd_fire, rsp_fire, walk_start;
  logic [VA_W-1:0] va_sel;
  logic [PA_W-1:0] slot_addr_w;
  logic va_canon;
  flt_e chk_reason;
  logic chk_w, chk_u, chk_nx;

  assign req_ready  = (st_q == ST_IDLE);
  assign busy       = (st_q != ST_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign mem_req_valid = (st_q == ST_RD_REQ);
  assign rd_fire    = mem_req_valid && mem_req_ready;
  assign rsp_fire   = (st_q == ST_RD_WAIT) && mem_rsp_valid;
  assign va_sel     = (st_q == ST_IDLE) ? req_vaddr : va_q;
  assign walk_start = req_fire && va_canon;

  pt_idx_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .LEVELS(LEVELS)
  ) u_idx (
    .va       (va_sel),
    .lvl      (lvl_q),
    .tbl_base (base_q),
    .ent_addr (slot_addr_w),
    .canon    (va_canon)
  );

  pt_perm_acc u_perm (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (req_fire),
    .upd    (rsp_fire),
    .pte_p  (mem_rsp_data[PTE_P]),
    .pte_rw (mem_rsp_data[PTE_RW]),
    .pte_us (mem_rsp_data[PTE_US]),
    .pte_nx (mem_rsp_data[PTE_NX]),
    .acc    (acc_q),
    .usr    (usr_q),
    .reason (chk_reason),
    .eff_w  (chk_w),
    .eff_u  (chk_u),
    .eff_nx (chk_nx)
  );

  assign mem_req_addr = slot_addr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      acc_q      <= ACC_READ;
      usr_q      <= 1'b0;
      base_q     <= '0;
      lvl_q      <= '0;
      res_fault  <= 1'b0;
      res_reason <= FLT_NONE;
      res_level  <= '0;
      res_paddr  <= '0;
      res_w      <= 1'b0;
      res_u      <= 1'b0;
      res_nx     <= 1'b0;
      res_a      <= 1'b0;
      res_d      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_fire) begin
            va_q   <= req_vaddr;
            acc_q  <= acc_e'(req_acc);
            usr_q  <= req_user;
            base_q <= {root_base[PA_W-1:OFS_W], {OFS_W{1'b0}}};
            lvl_q  <= TOP_LVL;
            if (walk_start) begin
              res_fault  <= 1'b0;
              res_reason <= FLT_NONE;
              st_q       <= ST_RD_REQ;
            end else begin
              res_fault  <= 1'b1;
              res_reason <= FLT_NONCANON;
              res_level  <= TOP_LVL;
              st_q       <= ST_DONE;
            end
          end
        end
        ST_RD_REQ: begin
          if (rd_fire) st_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rsp_fire) begin
            if (chk_reason != FLT_NONE) begin
              res_fault  <= 1'b1;
              res_reason <= chk_reason;
              res_level  <= lvl_q;
              st_q       <= ST_DONE;
            end else if (lvl_q == '0) begin
              res_paddr <= leaf_pa(mem_rsp_data, va_q);
              res_w     <= chk_w;
              res_u     <= chk_u;
              res_nx    <= chk_nx;
              res_a     <= mem_rsp_data[PTE_A];
              res_d     <= mem_rsp_data[PTE_D];
              st_q      <= ST_DONE;
            end else begin
              base_q <= next_base(mem_rsp_data);
              lvl_q  <= lvl_q - 1'b1;
              st_q   <= ST_RD_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_valid    = (st_q == ST_DONE);
  assign done_fault    = res_fault;
  assign done_paddr    = res_paddr;
  assign done_writable = res_w;
  assign done_user     = res_u;
  assign done_nx       = res_nx;
  assign done_accessed = res_a;
  assign done_dirty    = res_d;
  assign flt_vaddr     = va_q;
  assign flt_level     = 2'(res_level);
  assign flt_reason    = res_reason;

  logic unused_bits;
  assign unused_bits = ^{mem_rsp_data[62:PA_W], mem_rsp_data[OFS_W-1:7],
                         mem_rsp_data[4:3], root_base[OFS_W-1:0]};

  // read counter for the checks below
  logic [CNT_W-1:0] rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_cnt <= '0;
    else if (req_fire) rd_cnt <= '0;
    else if (rd_fire)  rd_cnt <= rd_cnt + 1'b1;
  end

  // R2
  noncanon_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !va_canon |=> done_valid && done_fault &&
      flt_reason == FLT_NONCANON && !mem_req_valid);
  // R4
  rd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= CNT_W'(LEVELS));
  // R4
  full_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_fault |-> rd_cnt == CNT_W'(LEVELS));
  // R5
  entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
  // R6
  leaf_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_fault |-> done_paddr[OFS_W-1:0] == flt_vaddr[OFS_W-1:0]);
  // R7
  absent_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && !mem_rsp_data[PTE_P] |=> done_valid && done_fault &&
      flt_reason == FLT_NOT_PRESENT);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && !busy);

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam logic [51:0] ROOT = 52'h1000;

  typedef struct packed {
    logic [63:0] va;
    logic        fault;
    logic [2:0]  reason;
    logic [1:0]  level;
    logic [51:0] paddr;
    logic        w, u, nx, a, d;
    logic [3:0]  nreads;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_user = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic mem_req_ready, mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic req_ready, busy, mem_req_valid, done_valid, done_fault;
  logic [51:0] mem_req_addr, done_paddr;
  logic done_writable, done_user, done_nx, done_accessed, done_dirty;
  logic [63:0] flt_vaddr;
  logic [1:0]  flt_level;
  logic [2:0]  flt_reason;

  int n_checks = 0, n_errs = 0, rd_seen = 0;
  bit stall_on = 0;
  logic [63:0] mem [logic [51:0]];
  exp_t sb_q[$];
  logic [51:0] exp_addr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_base(ROOT),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_fault(done_fault),
    .done_paddr(done_paddr), .done_writable(done_writable), .done_user(done_user),
    .done_nx(done_nx), .done_accessed(done_accessed), .done_dirty(done_dirty),
    .flt_vaddr(flt_vaddr), .flt_level(flt_level), .flt_reason(flt_reason)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // table slot of va at level lv inside table tb
  function automatic logic [51:0] slot(input logic [51:0] tb, input logic [63:0] va,
                                       input int lv);
    logic [63:0] i;
    i = (va >> (12 + 9*lv)) & 64'h1FF;
    return tb + 52'(i * 8);
  endfunction

  // flags: 64-bit flag pattern per level, tables t2..t0, frame base
  task automatic build(input logic [63:0] va, input logic [51:0] t2, t1, t0, frame,
                       input logic [63:0] f3, f2, f1, f0);
    mem[slot(ROOT, va, 3)] = f3 | {12'h0, t2[51:12], 12'h0};
    mem[slot(t2,   va, 2)] = f2 | {12'h0, t1[51:12], 12'h0};
    mem[slot(t1,   va, 1)] = f1 | {12'h0, t0[51:12], 12'h0};
    mem[slot(t0,   va, 0)] = f0 | {12'h0, frame[51:12], 12'h0};
  endtask

  task automatic ref_walk(input logic [63:0] va, input logic [1:0] acc,
                          input bit usr, output exp_t e);
    logic [51:0] tb, a;
    logic [63:0] ent;
    bit w, u, nx;
    e = '0;
    e.va = va;
    ent = '0;
    if (va[63:48] != {16{va[47]}}) begin
      e.fault = 1; e.reason = 3'd5; e.level = 2'd3;
      return;
    end
    tb = ROOT; w = 1; u = 1; nx = 0;
    for (int lv = 3; lv >= 0; lv--) begin
      a = slot(tb, va, lv);
      exp_addr.push_back(a);
      e.nreads = e.nreads + 1'b1;
      ent = rd(a);
      if (!ent[0]) begin
        e.fault = 1; e.reason = 3'd1; e.level = 2'(lv);
        return;
      end
      w = w & ent[1]; u = u & ent[2]; nx = nx | ent[63];
      if (usr && !u)                  begin e.fault = 1; e.reason = 3'd3; end
      else if (acc == 2'd1 && !w)     begin e.fault = 1; e.reason = 3'd2; end
      else if (acc == 2'd2 && nx)     begin e.fault = 1; e.reason = 3'd4; end
      if (e.fault) begin
        e.level = 2'(lv);
        return;
      end
      tb = {ent[51:12], 12'h0};
    end
    e.paddr = {tb[51:12], va[11:0]};
    e.w = w; e.u = u; e.nx = nx; e.a = ent[5]; e.d = ent[6];
  endtask

  // driver: push expected item, then present the request
  task automatic send(input logic [63:0] va, input logic [1:0] acc, input bit usr);
    exp_t e;
    ref_walk(va, acc, usr, e);
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R11: walk in progress blocks further requests
    chk(busy && !req_ready, "R11 busy/req_ready after accept",
        {62'h0, busy, req_ready}, 64'h2);
  endtask

  // memory responder
  initial begin
    logic [51:0] a, hold_addr;
    bit hold_pend;
    hold_pend = 0;
    hold_addr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hold_pend) begin
        chk(mem_req_valid && mem_req_addr == hold_addr, "R12 stalled request held",
            {12'h0, mem_req_addr}, {12'h0, hold_addr});
        hold_pend = 0;
      end
      mem_req_ready = stall_on ? ($urandom_range(0, 2) == 0) : 1'b1;
      if (mem_req_valid && !mem_req_ready) begin
        hold_pend = 1; hold_addr = mem_req_addr;
      end
      if (mem_req_valid && mem_req_ready) begin
        a = mem_req_addr;
        rd_seen++;
        if (exp_addr.size() == 0)
          chk(0, "R4 unexpected extra read", {12'h0, a}, 64'h0);
        else begin
          logic [51:0] ea;
          ea = exp_addr.pop_front();
          chk(a == ea, "R3 R5 entry read address", {12'h0, a}, {12'h0, ea});
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (stall_on ? $urandom_range(0, 3) : 0) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(a);
      end
    end
  end

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (done_valid) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          chk(0, "R13 result with no request", 64'h1, 64'h0);
        end else begin
          e = sb_q.pop_front();
          chk(rd_seen == int'(e.nreads), "R4 read count", 64'(rd_seen), 64'(e.nreads));
          chk(done_fault == e.fault, "R10 fault flag", 64'(done_fault), 64'(e.fault));
          if (e.fault) begin
            chk(flt_vaddr == e.va, "R10 fault vaddr", flt_vaddr, e.va);
            chk(flt_level == e.level, "R10 fault level", 64'(flt_level), 64'(e.level));
            chk(flt_reason == e.reason, "R10 fault reason", 64'(flt_reason), 64'(e.reason));
            if (e.reason == 3'd5)
              chk(rd_seen == 0, "R2 non-canonical issues no read", 64'(rd_seen), 64'h0);
            if (e.reason == 3'd1)
              chk(flt_reason == 3'd1 && flt_level == e.level, "R7 not-present stop",
                  {59'h0, flt_level, flt_reason}, {59'h0, e.level, 3'd1});
            if (e.reason >= 3'd2 && e.reason <= 3'd4)
              chk(flt_reason == e.reason, "R8 permission reason",
                  64'(flt_reason), 64'(e.reason));
          end else begin
            chk(done_paddr == e.paddr, "R6 physical address",
                {12'h0, done_paddr}, {12'h0, e.paddr});
            if (e.va[47])
              chk(done_paddr == e.paddr, "R1 high-half canonical walk",
                  {12'h0, done_paddr}, {12'h0, e.paddr});
            chk({done_writable, done_user, done_nx, done_accessed, done_dirty} ==
                {e.w, e.u, e.nx, e.a, e.d}, "R9 result flags",
                64'({done_writable, done_user, done_nx, done_accessed, done_dirty}),
                64'({e.w, e.u, e.nx, e.a, e.d}));
          end
        end
        rd_seen = 0;
        @(negedge clk);
        chk(!done_valid, "R13 done is a single pulse", 64'(done_valid), 64'h0);
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  localparam logic [63:0] VA_A = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] VA_B = 64'hFFFF_8123_4567_8DEF;
  localparam logic [63:0] VA_C = 64'h0000_2000_0000_0010;
  localparam logic [63:0] VA_D = 64'h0000_3000_0040_2008;
  localparam logic [63:0] VA_E = 64'h0000_4000_0000_3FFC;
  localparam logic [63:0] VA_F = 64'h0000_5000_0000_0000;
  localparam logic [63:0] VA_G = 64'h0000_7F00_0000_0000;
  localparam logic [63:0] NX   = 64'h8000_0000_0000_0000;

  task automatic run_set();
    send(VA_A, 2'd0, 1'b1);
    send(VA_A, 2'd1, 1'b0);
    send(VA_A, 2'd2, 1'b1);
    send(VA_B, 2'd0, 1'b0);
    send(64'h0000_8000_0000_0000, 2'd0, 1'b0);
    send(64'hFFFF_7FFF_FFFF_F000, 2'd1, 1'b1);
    send(VA_C, 2'd0, 1'b0);
    send(VA_G, 2'd0, 1'b1);
    send(VA_D, 2'd1, 1'b0);
    send(VA_D, 2'd0, 1'b1);
    send(VA_E, 2'd1, 1'b1);
    send(VA_E, 2'd1, 1'b0);
    send(VA_E, 2'd3, 1'b0);
    send(VA_F, 2'd2, 1'b0);
    send(VA_F, 2'd0, 1'b1);
  endtask

  initial begin
    build(VA_A, 52'h2000, 52'h3000, 52'h4000, 52'hA_BCDE_F000, 64'h7, 64'h7, 64'h7, 64'h67);
    build(VA_B, 52'h5000, 52'h6000, 52'h7000, 52'h7_7777_7000, 64'h7, 64'h7, 64'h7, 64'h27);
    build(VA_C, 52'h8000, 52'h9000, 52'hA000, 52'h1_0000_0000, 64'h7, 64'h7, 64'h6, 64'h7);
    build(VA_D, 52'hB000, 52'hC000, 52'hD000, 52'h1_2345_6000, 64'h7, 64'h5, 64'h7, 64'h7);
    build(VA_E, 52'hE000, 52'hF000, 52'h10000, 52'h2_0000_0000, 64'h7, 64'h7, 64'h7, 64'h1);
    build(VA_F, 52'h11000, 52'h12000, 52'h13000, 52'h3_0000_0000,
          NX | 64'h7, 64'h7, 64'h7, 64'h47);
    repeat (3) @(negedge clk);
    // reset state (R11, R13)
    chk(!busy && req_ready, "R11 idle during reset", {62'h0, busy, req_ready}, 64'h1);
    chk(!done_valid && !mem_req_valid, "R13 no result or read in reset",
        {62'h0, done_valid, mem_req_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_set();
    stall_on = 1;
    run_set();
    while (sb_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_addr.size() == 0, "R4 all expected reads issued", 64'(exp_addr.size()), 64'h0);
    summary();
    $finish;
  end

endmodule